// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This block sits beside an I2C master/slave engine and turns the engine's one-cycle event pulses into sticky status flags. It holds them in a 16-bit status word, masks them with an interrupt enable word, and drives a single registered interrupt line. Software clears a flag by writing a one to its bit position. Writing a zero to a bit leaves that bit alone. The bus-busy bit of the status word is a live copy of the bus state. It is not latched and it never interrupts.

Older software does not scan the status word. For that case a legacy mode input turns one register offset into a read-to-clear vector. The vector returns a small code for the most urgent enabled pending event and clears only that event. The same offset is also written as the wakeup enable mask. That mask selects which conditions raise a registered wakeup request: status events, a general-call pulse, a start-condition pulse, and the bus going free.

The interrupt line is driven by a two-state machine. LINE_QUIET moves to LINE_RAISED when any enabled flag is pending, and LINE_RAISED moves back to LINE_QUIET when none is pending. Both moves are taken at the clock edge that follows the change in flags.

Top module: `irq_vec_unit`

## Requirements
- R1: The engine reports events on `evt_set`. They are latched into the status word at these bits: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 RX drain, 14 TX drain. Event bits 5, 6, 7, 12 and 15 are ignored. A latched flag can be read at the clock edge that follows its pulse.
- R2: A write to the status offset (word address 1) clears every latched flag whose `reg_wdata` bit is one. Flags whose `reg_wdata` bit is zero keep their value, and a write has no effect on bit 12.
- R3: If an event and a write-one-to-clear hit the same bit in the same cycle, the flag stays set.
- R4: Status bit 12 reads the present level of `bus_busy`. It never raises `irq_o`.
- R5: The enable register sits at word address 0. Only bits 0–4, 13 and 14 are writable, and every other bit reads zero.
- R6: `irq_o` is the OR of (status AND enable), registered once. It rises one edge after the flag is latched, so two edges after the event pulse.
- R7: With `legacy_mode` high, a read at word address 2 returns the vector code in bits 2:0, with all other bits zero. The codes are 0 for none, 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready and 5 transmit ready. Only flags that are both set and enabled count, and the lowest nonzero code wins.
- R8: A legacy vector read clears only the flag that it reports. With `legacy_mode` low, a read at word address 2 returns the wakeup enable mask and clears nothing.
- R9: A write at word address 2 sets the wakeup enable mask. Only bits 0, 1, 2, 3, 5, 6, 8, 9, 13 and 14 are writable.
- R10: `wake_o` is registered high one edge after an enabled source is present. The sources are:
  - bit 0: arbitration-lost flag
  - bit 1: no-acknowledge flag
  - bit 2: access-ready flag
  - bit 3: receive-ready or transmit-ready flag
  - bit 5: `gencall_evt` pulse
  - bit 6: `start_evt` pulse
  - bit 8: `bus_busy` falling since the previous edge
  - bit 9: addressed-as-slave flag
  - bits 13 and 14: the drain flags
- R11: After reset, the status flags, the enable word, the wakeup mask, `irq_o` and `wake_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Selects the read-to-clear vector at word address 2 |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; causes the side effect of a vector read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| evt_set | input | 16 | One-cycle event pulses from the engine, at status positions |
| gencall_evt | input | 1 | General-call pulse (wakeup only) |
| start_evt | input | 1 | Start-condition pulse (wakeup only) |
| bus_busy | input | 1 | Bus busy level |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench builds the block with its defaults: a 2-bit address and word offsets 0, 1 and 2 for enable, status and vector/wakeup. It also uses all five vector sources, so every legacy code from 0 to 5 can be read back in priority order. With these values the bench can reach the shared offset in both modes. It can also reach a clear that coincides with a new event, and the bus-free edge that drives the wakeup request.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int REG_W = 16;

    // status / enable bit positions (software decodes these)
    localparam int B_ARB   = 0;
    localparam int B_NACK  = 1;
    localparam int B_ARDY  = 2;
    localparam int B_RRDY  = 3;
    localparam int B_XRDY  = 4;
    localparam int B_ADZ   = 8;
    localparam int B_SLV   = 9;
    localparam int B_XUND  = 10;
    localparam int B_ROVF  = 11;
    localparam int B_BUSY  = 12;
    localparam int B_RDRN  = 13;
    localparam int B_XDRN  = 14;

    // wakeup-only positions
    localparam int W_DRDY  = 3;
    localparam int W_GCALL = 5;
    localparam int W_START = 6;
    localparam int W_BFREE = 8;

    localparam logic [REG_W-1:0] LATCH_MASK = 16'h6F1F;
    localparam logic [REG_W-1:0] EN_MASK    = 16'h601F;
    localparam logic [REG_W-1:0] WAKE_MASK  = 16'h636F;

    typedef enum logic [2:0] {
        VEC_NONE = 3'd0,
        VEC_ARB  = 3'd1,
        VEC_NACK = 3'd2,
        VEC_ARDY = 3'd3,
        VEC_RRDY = 3'd4,
        VEC_XRDY = 3'd5
    } vec_code_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import i2c_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_set,
    input  logic [REG_W-1:0] clr_bits,
    input  logic [REG_W-1:0] vec_clr,
    output logic [REG_W-1:0] stat_q
);

    logic [REG_W-1:0] stat_d;

    // a fresh event outranks any clear in the same cycle
    always_comb begin
        stat_d = (evt_set | (stat_q & ~(clr_bits | vec_clr))) & LATCH_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

endmodule

// File: rtl/irq_vector_enc.sv
module irq_vector_enc #(
    parameter int NSRC = 5,
    localparam int CW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0] pend,
    output logic [CW-1:0]   code,
    output logic [NSRC-1:0] onehot
);

    // scan from the top so the lowest pending index is left standing
    always_comb begin
        code   = '0;
        onehot = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                code   = CW'(i + 1);
                onehot = NSRC'(1) << i;
            end
        end
    end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import i2c_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic wake_req,
    output logic irq_o,
    output logic wake_o
);

    line_state_e state_q;
    line_state_e state_d;
    logic        wake_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (irq_req)  state_d = LINE_RAISED;
            LINE_RAISED: if (!irq_req) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_req;
        end
    end

    always_comb begin
        irq_o  = (state_q == LINE_RAISED);
        wake_o = wake_q;
    end

endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int OFS_EN  = 0,
    parameter int OFS_ST  = 1,
    parameter int OFS_VEC = 2,
    parameter int NSRC    = 5,
    localparam int CW     = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_mode,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [REG_W-1:0]  evt_set,
    input  logic              gencall_evt,
    input  logic              start_evt,
    input  logic              bus_busy,
    output logic              irq_o,
    output logic              wake_o
);

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_ST);
    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VEC);

    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] wake_en_q;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] pend_all;
    logic [REG_W-1:0] clr_bits;
    logic [REG_W-1:0] vec_clr;
    logic [REG_W-1:0] wake_src;
    logic [CW-1:0]    vec_code;
    logic [NSRC-1:0]  vec_onehot;
    logic             vec_rd;
    logic             busy_q;
    logic             irq_req;
    logic             wake_req;

    // ---------------- control registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            wake_en_q <= '0;
            busy_q    <= 1'b0;
        end else begin
            busy_q <= bus_busy;
            if (reg_wr && reg_addr == A_EN) begin
                en_q <= reg_wdata & EN_MASK;
            end
            if (reg_wr && reg_addr == A_VEC) begin
                wake_en_q <= reg_wdata & WAKE_MASK;
            end
        end
    end

    // ---------------- status flags ----------------
    always_comb begin
        clr_bits = (reg_wr && reg_addr == A_ST) ? reg_wdata : '0;
        vec_rd   = reg_rd && legacy_mode && (reg_addr == A_VEC);
        vec_clr  = '0;
        if (vec_rd) begin
            vec_clr[NSRC-1:0] = vec_onehot;
        end
    end

    irq_status_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set & LATCH_MASK),
        .clr_bits (clr_bits),
        .vec_clr  (vec_clr),
        .stat_q   (stat_q)
    );

    // ---------------- vector encoder ----------------
    assign pend_all = stat_q & en_q;

    irq_vector_enc #(.NSRC(NSRC)) u_enc (
        .pend   (pend_all[NSRC-1:0]),
        .code   (vec_code),
        .onehot (vec_onehot)
    );

    // ---------------- wakeup sources ----------------
    always_comb begin
        wake_src          = '0;
        wake_src[B_ARB]   = stat_q[B_ARB];
        wake_src[B_NACK]  = stat_q[B_NACK];
        wake_src[B_ARDY]  = stat_q[B_ARDY];
        wake_src[W_DRDY]  = stat_q[B_RRDY] | stat_q[B_XRDY];
        wake_src[W_GCALL] = gencall_evt;
        wake_src[W_START] = start_evt;
        wake_src[W_BFREE] = busy_q & ~bus_busy;
        wake_src[B_SLV]   = stat_q[B_SLV];
        wake_src[B_RDRN]  = stat_q[B_RDRN];
        wake_src[B_XDRN]  = stat_q[B_XDRN];
        wake_req          = |(wake_src & wake_en_q);
        irq_req           = |pend_all;
    end

    irq_line_fsm u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .wake_req (wake_req),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_EN) begin
            reg_rdata = en_q;
        end else if (reg_addr == A_ST) begin
            reg_rdata         = stat_q;
            reg_rdata[B_BUSY] = bus_busy;
        end else if (reg_addr == A_VEC) begin
            if (legacy_mode) begin
                reg_rdata[CW-1:0] = vec_code;
            end else begin
                reg_rdata = wake_en_q;
            end
        end
    end

endmodule

// File: rtl/irq_vec_unit_chk.sv
module irq_vec_unit_chk
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int OFS_ST  = 1,
    parameter int OFS_VEC = 2,
    parameter int CW      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              legacy_mode,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  evt_set,
    input logic              bus_busy,
    input logic              irq_o,
    input logic [REG_W-1:0]  stat_q,
    input logic [REG_W-1:0]  en_q,
    input logic [CW-1:0]     vec_code
);

    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_ST);
    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VEC);

    logic vec_read;
    logic st_write;
    assign vec_read = reg_rd && legacy_mode && reg_addr == A_VEC;
    assign st_write = reg_wr && reg_addr == A_ST;

    p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(stat_q & en_q)));

    p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_set & LATCH_MASK)) |=>
        ((stat_q & $past(evt_set & LATCH_MASK)) == $past(evt_set & LATCH_MASK)));

    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_write && |(reg_wdata & LATCH_MASK & ~evt_set)) |=>
        ((stat_q & $past(reg_wdata & LATCH_MASK & ~evt_set)) == '0));

    p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && (stat_q & en_q) == '0) |=> !irq_o);

    p_vec_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_read && !st_write) |=> ($countones($past(stat_q) & ~stat_q) <= 1));

    p_vec_arb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_read && !st_write && vec_code == CW'(1) && !evt_set[B_ARB]) |=>
        !stat_q[B_ARB]);

endmodule

bind irq_vec_unit irq_vec_unit_chk #(
    .ADDR_W (ADDR_W),
    .OFS_ST (OFS_ST),
    .OFS_VEC(OFS_VEC),
    .CW     (CW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .legacy_mode(legacy_mode),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .evt_set    (evt_set),
    .bus_busy   (bus_busy),
    .irq_o      (irq_o),
    .stat_q     (stat_q),
    .en_q       (en_q),
    .vec_code   (vec_code)
);

// File: tb/irq_vec_unit_tb_top.sv
module irq_vec_unit_tb_top;

    localparam logic [1:0] A_EN  = 2'd0;
    localparam logic [1:0] A_ST  = 2'd1;
    localparam logic [1:0] A_VEC = 2'd2;
    localparam int NROW = 9;

    // {enable, event, expected status, expected irq}
    localparam logic [48:0] TBL [NROW] = '{
        {16'h0001, 16'h0001, 16'h0001, 1'b1},
        {16'h0000, 16'h0001, 16'h0001, 1'b0},
        {16'h6000, 16'h4000, 16'h4000, 1'b1},
        {16'h001F, 16'h0F00, 16'h0F00, 1'b0},
        {16'hFFFF, 16'h80E0, 16'h0000, 1'b0},
        {16'h0010, 16'h0018, 16'h0018, 1'b1},
        {16'h0008, 16'h2010, 16'h2010, 1'b0},
        {16'h2000, 16'h2000, 16'h2000, 1'b1},
        {16'hFFFF, 16'h1000, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_mode = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_set = '0;
    logic        gencall_evt = 1'b0;
    logic        start_evt = 1'b0;
    logic        bus_busy = 1'b0;
    logic        irq_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] rv;

    always #10 clk = ~clk;

    irq_vec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
        .gencall_evt(gencall_evt), .start_evt(start_evt), .bus_busy(bus_busy),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(A_EN, rv);  chk("R11 enable", rv, 16'h0000);
        rd(A_ST, rv);  chk("R11 status", rv, 16'h0000);
        rd(A_VEC, rv); chk("R11 wake mask", rv, 16'h0000);
        chk("R11 irq", {15'b0, irq_o}, 16'h0000);
        chk("R11 wake", {15'b0, wake_o}, 16'h0000);

        // R5 enable write mask
        wr(A_EN, 16'hFFFF);
        rd(A_EN, rv); chk("R5 enable mask", rv, 16'h601F);

        // R1 / R6 table
        for (int i = 0; i < NROW; i++) begin
            wr(A_ST, 16'hFFFF);
            wr(A_EN, TBL[i][48:33]);
            pulse(TBL[i][32:17]);
            @(negedge clk);
            rd(A_ST, rv);
            chk($sformatf("R1 row %0d status", i), rv, TBL[i][16:1]);
            chk($sformatf("R6 row %0d irq", i), {15'b0, irq_o}, {15'b0, TBL[i][0]});
        end

        // R6 timing: not yet high one edge after latch... high after second
        wr(A_ST, 16'hFFFF);
        wr(A_EN, 16'h0002);
        @(negedge clk);
        evt_set = 16'h0002;
        @(negedge clk);
        evt_set = '0;
        chk("R6 irq not yet", {15'b0, irq_o}, 16'h0000);
        @(negedge clk);
        chk("R6 irq raised", {15'b0, irq_o}, 16'h0001);

        // R2 write-one-to-clear
        wr(A_ST, 16'hFFFF);
        pulse(16'h0F1F);
        wr(A_ST, 16'h0003);
        rd(A_ST, rv); chk("R2 partial clear", rv, 16'h0F1C);
        wr(A_ST, 16'h0000);
        rd(A_ST, rv); chk("R2 zero write", rv, 16'h0F1C);

        // R3 event wins over clear
        wr(A_ST, 16'hFFFF);
        pulse(16'h0006);
        @(negedge clk);
        reg_addr = A_ST; reg_wdata = 16'h0006; reg_wr = 1'b1; evt_set = 16'h0004;
        @(negedge clk);
        reg_wr = 1'b0; evt_set = '0;
        rd(A_ST, rv); chk("R3 event wins", rv, 16'h0004);

        // R4 bus busy level
        wr(A_ST, 16'hFFFF);
        wr(A_EN, 16'hFFFF);
        bus_busy = 1'b1;
        wr(A_ST, 16'h1000);
        rd(A_ST, rv); chk("R4 busy bit", rv, 16'h1000);
        @(negedge clk);
        chk("R4 no irq", {15'b0, irq_o}, 16'h0000);
        bus_busy = 1'b0;
        rd(A_ST, rv); chk("R4 busy gone", rv, 16'h0000);

        // R7 / R8 legacy vector
        legacy_mode = 1'b1;
        wr(A_EN, 16'h001F);
        pulse(16'h001E);
        rd(A_VEC, rv); chk("R7 code nack", rv, 16'h0002);
        rd(A_VEC, rv); chk("R8 next ardy", rv, 16'h0003);
        rd(A_VEC, rv); chk("R8 next rrdy", rv, 16'h0004);
        rd(A_VEC, rv); chk("R8 next xrdy", rv, 16'h0005);
        rd(A_VEC, rv); chk("R7 none", rv, 16'h0000);
        rd(A_ST, rv);  chk("R8 all cleared", rv, 16'h0000);
        pulse(16'h0011);
        rd(A_VEC, rv); chk("R7 arb first", rv, 16'h0001);
        rd(A_ST, rv);  chk("R8 only arb cleared", rv, 16'h0010);
        wr(A_ST, 16'hFFFF);
        wr(A_EN, 16'h0001);
        pulse(16'h0010);
        rd(A_VEC, rv); chk("R7 disabled not reported", rv, 16'h0000);
        rd(A_ST, rv);  chk("R8 disabled kept", rv, 16'h0010);

        // R8 / R9 non-legacy shared offset
        legacy_mode = 1'b0;
        wr(A_EN, 16'h0010);
        wr(A_VEC, 16'hFFFF);
        rd(A_VEC, rv); chk("R9 wake mask", rv, 16'h636F);
        rd(A_ST, rv);  chk("R8 no clear non-legacy", rv, 16'h0010);

        // R10 wakeup
        wr(A_ST, 16'hFFFF);
        wr(A_VEC, 16'h0020);
        @(negedge clk);
        gencall_evt = 1'b1;
        @(negedge clk);
        gencall_evt = 1'b0;
        chk("R10 gencall wake", {15'b0, wake_o}, 16'h0001);
        @(negedge clk);
        chk("R10 wake drops", {15'b0, wake_o}, 16'h0000);
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        chk("R10 start masked", {15'b0, wake_o}, 16'h0000);
        wr(A_VEC, 16'h0100);
        bus_busy = 1'b1;
        repeat (2) @(negedge clk);
        bus_busy = 1'b0;
        @(negedge clk);
        chk("R10 bus free wake", {15'b0, wake_o}, 16'h0001);
        wr(A_VEC, 16'h0008);
        pulse(16'h0010);
        @(negedge clk);
        chk("R10 data ready wake", {15'b0, wake_o}, 16'h0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule